// File: doc/BRIEF.md
# Triggered One-Shot Waveform Player

This block plays a stored waveform table exactly once each time it is triggered. While idle it holds its output. A trigger pulse clears its internal counters and starts a pass at table address 0. Every table entry is then read out in ascending address order. After the final entry has been delivered, the block returns to idle.

Playback speed is set by a fractional rate generator. This is a modular accumulator that adds a step `S` each clock and wraps against a limit `L`. Each wrap advances the table address by one, so the table is read at `S/L` entries per clock. The table is a synchronous-read memory filled at elaboration from a computed triangle pattern. Each word it returns is marked by a one-cycle valid pulse.

Top module: `wave_oneshot_player`

## Requirements
- R1: While idle (`busy` low), a high `trigIn` sampled at a rising edge starts a pass: `busy` is high from the next cycle, and the first entry read is address 0.
- R2: The rate accumulator starts each pass at 0. On every busy clock, if its value `c` satisfies `c >= L-S`, it becomes `c-(L-S)` and the table address advances by one. Otherwise it becomes `c+S`.
- R3: A pass keeps `busy` high for exactly ceil(DEPTH*L/S) clock cycles.
- R4: A pass delivers exactly DEPTH samples, from address 0 to DEPTH-1 in ascending order. `busy` falls at the same edge that registers the last sample.
- R5: Table reads are synchronous. `sampleOut` updates one clock after the address step that selects it, and holds its value at all other times.
- R6: A trigger that arrives while `busy` is high has no effect on the running pass or on its length.
- R7: Both counters are cleared when a pass starts. Two passes with the same `L` and `S` therefore have identical timing, whatever state the previous pass left behind.
- R8: `sampleValid` is high for exactly the one cycle in which each new sample first appears on `sampleOut`, and is low otherwise.
- R9: Table entry i holds t*SLOPE mod 2^DATA_W, where t = i for i < DEPTH/2 and t = DEPTH-1-i otherwise.
- R10: Synchronous reset (`rst` high) drives `busy`, `sampleValid` and `sampleOut` to 0, and abandons any pass in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| trigIn | input | 1 | Start request; acted on only while idle |
| rateLimit | input | RATE_W | Rate accumulator limit L (1 <= S <= L) |
| rateStep | input | RATE_W | Rate accumulator step S |
| sampleOut | output | DATA_W | Current table sample |
| sampleValid | output | 1 | One-cycle pulse marking a new sample |
| busy | output | 1 | High while a pass is in progress |

## Verification
The bench exercises several step/limit ratios: S equal to L (one entry per clock), small fractions such as 2/3 and 3/5, and a very slow ratio of 1/255. A rate accumulator that wrapped to 0 instead of keeping its remainder would stretch these passes, and the pass-length checks would expose it. The bench also retriggers in mid-pass and holds the trigger high across the end of a pass. A control path that did not ignore busy triggers would restart at address 0 and emit extra samples. Back-to-back passes, and a reset taken in mid-pass, catch counters left uncleared between passes and a read pipeline that drops or duplicates the final table entry.

// File: rtl/wop_pkg.sv
package wop_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;  // clear both counters, new pass begins
    logic run;    // pass in progress, counters may advance
  } wop_ctrl_t;

  // Triangle pattern used to fill the table
  function automatic int unsigned triWave(int unsigned idx, int unsigned depth,
                                          int unsigned slope);
    int unsigned t;
    t = (idx < depth / 2) ? idx : (depth - 1 - idx);
    return t * slope;
  endfunction

endpackage

// File: rtl/wop_mod_counter.sv
module wop_mod_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  input  logic [CNT_W-1:0] step,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);

  logic [CNT_W-1:0] gap;
  logic [CNT_W-1:0] nextCount;

  always_comb begin
    gap       = limit - step;
    wrap      = (count >= gap);
    nextCount = wrap ? (count - gap) : (count + step);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (en)    count <= nextCount;
  end

  AST_COUNTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(count));  // R2
  AST_COUNTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));  // R7

endmodule

// File: rtl/wop_wave_table.sv
module wop_wave_table import wop_pkg::*; #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 64,
  parameter int SLOPE  = 37,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] romArr [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rom
    assign romArr[gi] = DATA_W'(triWave(gi, DEPTH, SLOPE));
  end

  always_ff @(posedge clk) begin
    if (rst)       rdData <= '0;
    else if (rdEn) rdData <= romArr[rdAddr];
  end

  AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> $stable(rdData));  // R5

endmodule

// File: rtl/wop_datapath.sv
module wop_datapath import wop_pkg::*; #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 64,
  parameter int RATE_W = 8,
  parameter int SLOPE  = 37,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int ACNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  wop_ctrl_t         ctrl,
  input  logic [RATE_W-1:0] rateLimit,
  input  logic [RATE_W-1:0] rateStep,
  output logic [DATA_W-1:0] sampleOut,
  output logic              sampleValid,
  output logic              passDone
);

  logic [RATE_W-1:0] rateCount;
  logic              rateWrap;
  logic [ACNT_W-1:0] addrCount;
  logic              addrWrap;
  logic              stepEn;

  assign stepEn   = ctrl.run & rateWrap;
  assign passDone = stepEn & addrWrap;

  wop_mod_counter #(.CNT_W(RATE_W)) u_rate (
    .clk   (clk),
    .rst   (rst),
    .clr   (ctrl.start),
    .en    (ctrl.run),
    .limit (rateLimit),
    .step  (rateStep),
    .count (rateCount),
    .wrap  (rateWrap)
  );

  wop_mod_counter #(.CNT_W(ACNT_W)) u_addr (
    .clk   (clk),
    .rst   (rst),
    .clr   (ctrl.start),
    .en    (stepEn),
    .limit (ACNT_W'(DEPTH)),
    .step  (ACNT_W'(1)),
    .count (addrCount),
    .wrap  (addrWrap)
  );

  wop_wave_table #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SLOPE(SLOPE)) u_table (
    .clk    (clk),
    .rst    (rst),
    .rdEn   (stepEn),
    .rdAddr (addrCount[ADDR_W-1:0]),
    .rdData (sampleOut)
  );

  always_ff @(posedge clk) begin
    if (rst) sampleValid <= 1'b0;
    else     sampleValid <= stepEn;
  end

  AST_RATE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ctrl.run |-> (rateCount < rateLimit));  // R2
  AST_PASS_RESTART: assert property (@(posedge clk) disable iff (rst)
    passDone |=> (addrCount == '0));  // R4
  AST_ADDR_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
    addrCount < ACNT_W'(DEPTH));  // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (sampleOut == '0 && !sampleValid));  // R10

endmodule

// File: rtl/wop_ctrl.sv
module wop_ctrl import wop_pkg::*; (
  input  logic      clk,
  input  logic      rst,
  input  logic      trigIn,
  input  logic      passDone,
  output wop_ctrl_t ctrl,
  output logic      busy
);

  logic startReq;

  assign startReq   = trigIn & ~busy;
  assign ctrl.start = startReq;
  assign ctrl.run   = busy;

  always_ff @(posedge clk) begin
    if (rst)           busy <= 1'b0;
    else if (startReq) busy <= 1'b1;
    else if (passDone) busy <= 1'b0;
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    startReq |=> busy);  // R1
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && !passDone) |=> busy);  // R6
  AST_DONE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    passDone |-> busy);  // R4

endmodule

// File: rtl/wave_oneshot_player.sv
module wave_oneshot_player import wop_pkg::*; #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 64,
  parameter int RATE_W = 8,
  parameter int SLOPE  = 37
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trigIn,
  input  logic [RATE_W-1:0] rateLimit,
  input  logic [RATE_W-1:0] rateStep,
  output logic [DATA_W-1:0] sampleOut,
  output logic              sampleValid,
  output logic              busy
);

  wop_ctrl_t ctrlStb;
  logic      passDone;

  wop_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .trigIn   (trigIn),
    .passDone (passDone),
    .ctrl     (ctrlStb),
    .busy     (busy)
  );

  wop_datapath #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .RATE_W (RATE_W),
    .SLOPE  (SLOPE)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .ctrl        (ctrlStb),
    .rateLimit   (rateLimit),
    .rateStep    (rateStep),
    .sampleOut   (sampleOut),
    .sampleValid (sampleValid),
    .passDone    (passDone)
  );

  AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> $past(busy));  // R8

endmodule

// File: tb/wave_oneshot_player_tb.sv
module wave_oneshot_player_tb;
  localparam int DATA_W = 12;
  localparam int DEPTH  = 64;
  localparam int RATE_W = 8;
  localparam int SLOPE  = 37;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              trigIn = 1'b0;
  logic [RATE_W-1:0] rateLimit = 8'd1;
  logic [RATE_W-1:0] rateStep = 8'd1;
  logic [DATA_W-1:0] sampleOut;
  logic              sampleValid;
  logic              busy;

  int nRun = 0;
  int nFail = 0;
  int cyc = 0;

  wave_oneshot_player #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RATE_W(RATE_W), .SLOPE(SLOPE)) u_dut (
    .clk(clk), .rst(rst), .trigIn(trigIn), .rateLimit(rateLimit), .rateStep(rateStep),
    .sampleOut(sampleOut), .sampleValid(sampleValid), .busy(busy)
  );

  always #5 clk = ~clk;

  function automatic int refTable(int i);
    int t;
    if (i < DEPTH / 2) t = i;
    else t = DEPTH - 1 - i;
    return (t * SLOPE) % (1 << DATA_W);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference, advanced on every rising edge
  int mBusy = 0, mRate = 0, mAddr = 0, mOut = 0, mValid = 0;
  always @(posedge clk) begin
    int lim, stp, en;
    lim = rateLimit;
    stp = rateStep;
    cyc++;
    if (rst) begin
      mBusy = 0; mRate = 0; mAddr = 0; mOut = 0; mValid = 0;
    end else begin
      en = (mBusy != 0 && mRate >= lim - stp) ? 1 : 0;
      mValid = en;
      if (en != 0) mOut = refTable(mAddr);
      if (mBusy == 0 && trigIn) begin
        mBusy = 1; mRate = 0; mAddr = 0;
      end else if (mBusy != 0) begin
        if (mRate >= lim - stp) mRate = mRate - (lim - stp);
        else mRate = mRate + stp;
        if (en != 0) begin
          if (mAddr == DEPTH - 1) begin mAddr = 0; mBusy = 0; end
          else mAddr++;
        end
      end
    end
  end

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (cyc > 0) begin
      chk(int'(busy) == mBusy, "R1 busy vs model", int'(busy), mBusy);
      chk(int'(sampleValid) == mValid, "R8 valid vs model", int'(sampleValid), mValid);
      chk(int'(sampleOut) == mOut, "R5 data vs model", int'(sampleOut), mOut);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  // One pass; midTrig > 0 pulses trigIn during that busy cycle
  task automatic runPass(int lim, int stp, int midTrig, string req, output int len);
    int idx;
    rateLimit = RATE_W'(lim);
    rateStep  = RATE_W'(stp);
    @(negedge clk);
    trigIn = 1'b1;
    @(negedge clk);
    trigIn = 1'b0;
    chk(busy == 1'b1, "R1 busy after trigger", int'(busy), 1);
    len = 0;
    idx = 0;
    while (busy) begin
      len++;
      trigIn = (len == midTrig);
      @(negedge clk);
      if (sampleValid) begin
        chk(int'(sampleOut) == refTable(idx), "R9 table entry", int'(sampleOut), refTable(idx));
        idx++;
      end
    end
    trigIn = 1'b0;
    chk(idx == DEPTH, "R4 sample count", idx, DEPTH);
    chk(len == (DEPTH * lim + stp - 1) / stp, {req, " pass length R3"}, len,
        (DEPTH * lim + stp - 1) / stp);
  endtask

  initial begin
    int lenA, lenB;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 busy in reset", int'(busy), 0);
    chk(sampleValid == 1'b0, "R10 valid in reset", int'(sampleValid), 0);
    chk(sampleOut == '0, "R10 data in reset", int'(sampleOut), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    runPass(1, 1, 0, "R2 S=L", lenA);
    runPass(3, 2, 0, "R2 2/3", lenA);
    runPass(5, 3, 0, "R7 first", lenA);
    repeat (4) @(negedge clk);
    runPass(5, 3, 0, "R7 second", lenB);
    chk(lenA == lenB, "R7 equal timing", lenB, lenA);
    runPass(5, 3, 30, "R6 mid trigger", lenB);
    runPass(7, 1, 100, "R6 mid trigger slow", lenA);
    runPass(255, 1, 0, "R2 slow", lenA);
    runPass(255, 254, 0, "R2 near one", lenA);

    // Trigger held high across the end of a pass: restarts only once idle
    rateLimit = 8'd2;
    rateStep  = 8'd1;
    @(negedge clk);
    trigIn = 1'b1;
    repeat (2 * DEPTH * 2 + 10) @(negedge clk);
    trigIn = 1'b0;
    while (busy) @(negedge clk);
    chk(busy == 1'b0, "R1 idle after held trigger", int'(busy), 0);

    // Reset taken in mid-pass
    rateLimit = 8'd3;
    rateStep  = 8'd1;
    @(negedge clk);
    trigIn = 1'b1;
    @(negedge clk);
    trigIn = 1'b0;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R10 busy after mid reset", int'(busy), 0);
    chk(sampleOut == '0, "R10 data after mid reset", int'(sampleOut), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 stays idle", int'(busy), 0);
    runPass(4, 3, 0, "R7 after reset", lenA);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule